// File: doc/BRIEF.md
# Unified Multi-Port Dispatch Scheduler

This block is the single waiting pool that sits between rename and the execution ports of an out-of-order core. Renamed µops come in through a multi-lane allocate port. Each one is stored with its operation class, two source tags with their ready bits, a user identifier and an age stamp. Destination tags broadcast by producing units wake up sources that wait on them. Every cycle each of the eight typed execution ports takes the oldest fully ready µop whose class it is allowed to serve.

Selection runs through the ports in a fixed order, lowest port first. A µop taken by one port is hidden from every port after it, so one entry never issues twice in a cycle. A port that reports busy takes nothing, and its candidates stay in the pool. Allocation is all-or-nothing: a request group is accepted only when the pool has at least as many free entries as lanes requested.

Top module: `dispatch_sched`

## Requirements
- R1: `alloc_ok` is high exactly when the number of asserted `alloc_valid` lanes is no more than the number of free entries. When it is low, no lane is written and none of the offered µops ever issues.
- R2: Class codes are 0 ALU, 1 branch, 2 multiply/FMA, 3 load, 4 store-address and 5 store-data. The legal ports are: ALU on 0/1/5/6, branch on 0/6, multiply on 0/1, load on 2/3, store-address on 2/3/7 and store-data on 4 only. Codes 6 and 7 never issue.
- R3: Each port issues at most one µop per cycle, and an issued µop leaves the pool, so no µop appears on two ports or in two cycles.
- R4: Among the µops a port may take, it issues the one allocated earliest. Within one allocation cycle, lane 0 is older than lane 1. Age does not depend on which slot the entry landed in.
- R5: Ports choose in ascending index order. A lower port takes the oldest eligible µop before any higher port chooses.
- R6: A port whose `port_busy` bit is high issues nothing that cycle. Its waiting µops stay and issue once a legal port is free.
- R7: A wakeup tag that matches a waiting source makes it ready from the next cycle. A tag broadcast in the same cycle as the µop's allocation is also captured. A non-matching tag changes nothing.
- R8: A µop allocated with both sources ready can issue in the cycle after allocation, but not in the allocation cycle itself.
- R9: After synchronous reset the pool is empty, no port issues, and an allocation request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | ALLOC_N | Per-lane allocate request |
| alloc_cls | input | ALLOC_N x 3 | Per-lane operation class |
| alloc_src_tag | input | ALLOC_N x 2 x TAG_W | Per-lane source tags |
| alloc_src_rdy | input | ALLOC_N x 2 | Per-lane source ready at allocation |
| alloc_uid | input | ALLOC_N x UID_W | Per-lane µop identifier returned on issue |
| alloc_ok | output | 1 | Request group accepted |
| wake_valid | input | WAKE_N | Per-lane wakeup broadcast valid |
| wake_tag | input | WAKE_N x TAG_W | Broadcast destination tags |
| port_busy | input | 8 | Per-port stall |
| issue_valid | output | 8 | Per-port issue strobe |
| issue_uid | output | 8 x UID_W | Identifier of the µop issued on each port |
| issue_cls | output | 8 x 3 | Class of the µop issued on each port |

## Verification
The bench builds the scheduler with six entries, two allocate lanes, two wakeup lanes and a 5-bit age stamp. With these values a full pool is reached in three cycles. A partial refusal (one free slot, two requested) is easy to set up. Freeing slot 0 and refilling it lets a younger µop land below an older one, which shows that age, not slot index, decides the order. Busy masks steer each class across all of its legal ports, down to the case where none is free.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int NUM_PORTS = 8;
    localparam int CLS_W     = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU     = 3'd0,
        CLS_BRANCH  = 3'd1,
        CLS_MUL     = 3'd2,
        CLS_LOAD    = 3'd3,
        CLS_STADDR  = 3'd4,
        CLS_STDATA  = 3'd5
    } op_cls_e;

    // Ports allowed to serve a class, bit p = port p.
    function automatic logic [NUM_PORTS-1:0] port_mask(input logic [CLS_W-1:0] c);
        case (op_cls_e'(c))
            CLS_ALU:    port_mask = 8'b0110_0011;
            CLS_BRANCH: port_mask = 8'b0100_0001;
            CLS_MUL:    port_mask = 8'b0000_0011;
            CLS_LOAD:   port_mask = 8'b0000_1100;
            CLS_STADDR: port_mask = 8'b1000_1100;
            CLS_STDATA: port_mask = 8'b0001_0000;
            default:    port_mask = '0;
        endcase
    endfunction

endpackage

// File: rtl/sched_slot_alloc.sv
module sched_slot_alloc #(
    parameter int N     = 60,
    parameter int LANES = 4,
    localparam int IDX_W = $clog2(N),
    localparam int CNT_W = $clog2(N + 1) + 1
) (
    input  logic [N-1:0]                 used,
    input  logic [LANES-1:0]             req,
    output logic                         ok,
    output logic [LANES-1:0]             go,
    output logic [LANES-1:0][IDX_W-1:0]  slot
);

    logic [CNT_W-1:0] free_cnt;
    logic [CNT_W-1:0] req_cnt;
    logic [N-1:0]     claimed;
    logic             found;

    always_comb begin
        free_cnt = CNT_W'(N) - CNT_W'($countones(used));
        req_cnt  = CNT_W'($countones(req));
        ok       = (req_cnt <= free_cnt);
        go       = ok ? req : '0;
        claimed  = used;
        slot     = '0;
        found    = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            found = 1'b0;
            for (int i = 0; i < N; i++) begin
                if (req[l] && !found && !claimed[i]) begin
                    found      = 1'b1;
                    slot[l]    = IDX_W'(i);
                    claimed[i] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sched_oldest_pick.sv
module sched_oldest_pick #(
    parameter int N     = 60,
    parameter int SEQ_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N-1:0]                cand,
    input  logic [N-1:0][SEQ_W-1:0]     seq,
    input  logic                        busy,
    output logic [N-1:0]                gnt,
    output logic                        any
);

    logic [SEQ_W-1:0] best_seq;
    logic [SEQ_W-1:0] diff;

    // Wrapping age compare: a is older than b when (a - b) is negative.
    always_comb begin
        gnt      = '0;
        any      = 1'b0;
        best_seq = '0;
        diff     = '0;
        if (!busy) begin
            for (int i = 0; i < N; i++) begin
                diff = seq[i] - best_seq;
                if (cand[i] && (!any || diff[SEQ_W-1])) begin
                    any      = 1'b1;
                    best_seq = seq[i];
                    gnt      = '0;
                    gnt[i]   = 1'b1;
                end
            end
        end
    end

    // R6: a stalled port grants nothing
    p_busy_idle_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!any && gnt == '0));

endmodule

// File: rtl/dispatch_sched.sv
module dispatch_sched
    import sched_pkg::*;
#(
    parameter int NUM_ENTRIES = 60,
    parameter int ALLOC_N     = 4,
    parameter int WAKE_N      = 4,
    parameter int TAG_W       = 8,
    parameter int UID_W       = 8,
    parameter int SEQ_W       = 8,
    localparam int IDX_W = $clog2(NUM_ENTRIES),
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1) + 1
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [ALLOC_N-1:0]                      alloc_valid,
    input  logic [ALLOC_N-1:0][CLS_W-1:0]           alloc_cls,
    input  logic [ALLOC_N-1:0][1:0][TAG_W-1:0]      alloc_src_tag,
    input  logic [ALLOC_N-1:0][1:0]                 alloc_src_rdy,
    input  logic [ALLOC_N-1:0][UID_W-1:0]           alloc_uid,
    output logic                                    alloc_ok,
    input  logic [WAKE_N-1:0]                       wake_valid,
    input  logic [WAKE_N-1:0][TAG_W-1:0]            wake_tag,
    input  logic [NUM_PORTS-1:0]                    port_busy,
    output logic [NUM_PORTS-1:0]                    issue_valid,
    output logic [NUM_PORTS-1:0][UID_W-1:0]         issue_uid,
    output logic [NUM_PORTS-1:0][CLS_W-1:0]         issue_cls
);

    typedef struct packed {
        logic                   valid;
        logic [CLS_W-1:0]       cls;
        logic [1:0][TAG_W-1:0]  tag;
        logic [1:0]             rdy;
        logic [SEQ_W-1:0]       seq;
        logic [UID_W-1:0]       uid;
    } entry_t;

    entry_t ent_q [NUM_ENTRIES];
    logic [SEQ_W-1:0] seq_q;

    logic [NUM_ENTRIES-1:0]              valid_vec;
    logic [NUM_ENTRIES-1:0]              ready_vec;
    logic [NUM_ENTRIES-1:0][SEQ_W-1:0]   seq_vec;
    logic [NUM_ENTRIES-1:0][1:0]         wk;
    logic [NUM_PORTS-1:0][NUM_ENTRIES-1:0] cls_ok;
    logic [NUM_PORTS-1:0][NUM_ENTRIES-1:0] gnt;
    logic [NUM_PORTS:0][NUM_ENTRIES-1:0]   taken;
    logic [NUM_ENTRIES-1:0]              issued;

    logic [ALLOC_N-1:0]                  lane_go;
    logic [ALLOC_N-1:0][IDX_W-1:0]       lane_slot;
    entry_t                              lane_e [ALLOC_N];

    // ---------------- entry state view and wakeup match ----------------
    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            valid_vec[i] = ent_q[i].valid;
            ready_vec[i] = ent_q[i].valid & (&ent_q[i].rdy);
            seq_vec[i]   = ent_q[i].seq;
            for (int s = 0; s < 2; s++) begin
                wk[i][s] = 1'b0;
                for (int w = 0; w < WAKE_N; w++)
                    wk[i][s] = wk[i][s] | (wake_valid[w] && wake_tag[w] == ent_q[i].tag[s]);
            end
            for (int p = 0; p < NUM_PORTS; p++)
                cls_ok[p][i] = port_mask(ent_q[i].cls)[p];
        end
    end

    // ---------------- allocation ----------------
    sched_slot_alloc #(.N(NUM_ENTRIES), .LANES(ALLOC_N)) u_alloc (
        .used (valid_vec),
        .req  (alloc_valid),
        .ok   (alloc_ok),
        .go   (lane_go),
        .slot (lane_slot)
    );

    always_comb begin
        for (int l = 0; l < ALLOC_N; l++) begin
            lane_e[l].valid = 1'b1;
            lane_e[l].cls   = alloc_cls[l];
            lane_e[l].tag   = alloc_src_tag[l];
            lane_e[l].seq   = seq_q + SEQ_W'(l);
            lane_e[l].uid   = alloc_uid[l];
            for (int s = 0; s < 2; s++) begin
                lane_e[l].rdy[s] = alloc_src_rdy[l][s];
                for (int w = 0; w < WAKE_N; w++)
                    if (wake_valid[w] && wake_tag[w] == alloc_src_tag[l][s])
                        lane_e[l].rdy[s] = 1'b1;
            end
        end
    end

    // ---------------- per-port oldest-first selection chain ----------------
    assign taken[0] = '0;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic any_p;
        sched_oldest_pick #(.N(NUM_ENTRIES), .SEQ_W(SEQ_W)) u_pick (
            .clk  (clk),
            .rst  (rst),
            .cand (ready_vec & cls_ok[p] & ~taken[p]),
            .seq  (seq_vec),
            .busy (port_busy[p]),
            .gnt  (gnt[p]),
            .any  (any_p)
        );
        assign taken[p+1]     = taken[p] | gnt[p];
        assign issue_valid[p] = any_p;
    end

    assign issued = taken[NUM_PORTS];

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            issue_uid[p] = '0;
            issue_cls[p] = '0;
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (gnt[p][i]) begin
                    issue_uid[p] = issue_uid[p] | ent_q[i].uid;
                    issue_cls[p] = issue_cls[p] | ent_q[i].cls;
                end
            end
        end
    end

    // ---------------- state update ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENTRIES; i++) ent_q[i] <= '0;
            seq_q <= '0;
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (issued[i]) ent_q[i].valid <= 1'b0;
                for (int s = 0; s < 2; s++)
                    if (wk[i][s]) ent_q[i].rdy[s] <= 1'b1;
            end
            for (int l = 0; l < ALLOC_N; l++)
                if (lane_go[l]) ent_q[lane_slot[l]] <= lane_e[l];
            if (|lane_go) seq_q <= seq_q + SEQ_W'(ALLOC_N);
        end
    end

    // ---------------- assertions ----------------
    logic [CNT_W-1:0] occ_c, acc_c, iss_c;
    assign occ_c = CNT_W'($countones(valid_vec));
    assign acc_c = CNT_W'($countones(lane_go));
    assign iss_c = CNT_W'($countones(issued));

    // R1: occupancy moves only by accepted allocations and issues
    p_occupancy_r1: assert property (@(posedge clk) disable iff (rst)
        (|valid_vec || |alloc_valid) |=> occ_c == $past(occ_c) + $past(acc_c) - $past(iss_c));

    logic [NUM_PORTS-1:0] pm_iss [NUM_PORTS];
    always_comb
        for (int p = 0; p < NUM_PORTS; p++) pm_iss[p] = port_mask(issue_cls[p]);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk_port
        // R2: issued class is legal on this port
        p_legal_port_r2: assert property (@(posedge clk) disable iff (rst)
            issue_valid[p] |-> pm_iss[p][p]);
    end

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_chk_ent
        logic [NUM_PORTS-1:0] col;
        always_comb
            for (int p = 0; p < NUM_PORTS; p++) col[p] = gnt[p][i];
        // R3: an entry is granted by at most one port
        p_one_port_r3: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col));
        // R7: a matching wakeup makes the source ready next cycle
        p_wake_next_r7: assert property (@(posedge clk) disable iff (rst)
            (ent_q[i].valid && !issued[i] && wk[i][0]) |=> ent_q[i].rdy[0]);
    end

endmodule

// File: tb/dispatch_sched_tb.sv
module dispatch_sched_tb;

    localparam int NE = 6;
    localparam int AN = 2;
    localparam int WN = 2;
    localparam int TW = 6;
    localparam int UW = 8;
    localparam int SW = 5;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic [AN-1:0]              a_v;
    logic [AN-1:0][2:0]         a_cls;
    logic [AN-1:0][1:0][TW-1:0] a_tag;
    logic [AN-1:0][1:0]         a_rdy;
    logic [AN-1:0][UW-1:0]      a_uid;
    logic                       a_ok;
    logic [WN-1:0]              w_v;
    logic [WN-1:0][TW-1:0]      w_tag;
    logic [7:0]                 busy;
    logic [7:0]                 iv;
    logic [7:0][UW-1:0]         iuid;
    logic [7:0][2:0]            icls;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    dispatch_sched #(
        .NUM_ENTRIES(NE), .ALLOC_N(AN), .WAKE_N(WN),
        .TAG_W(TW), .UID_W(UW), .SEQ_W(SW)
    ) u_dut (
        .clk(clk), .rst(rst),
        .alloc_valid(a_v), .alloc_cls(a_cls), .alloc_src_tag(a_tag),
        .alloc_src_rdy(a_rdy), .alloc_uid(a_uid), .alloc_ok(a_ok),
        .wake_valid(w_v), .wake_tag(w_tag), .port_busy(busy),
        .issue_valid(iv), .issue_uid(iuid), .issue_cls(icls)
    );

    // {class, busy mask, expected issue mask} for one ready µop alone
    localparam logic [18:0] VEC [17] = '{
        {3'd0, 8'h00, 8'h01}, {3'd0, 8'h01, 8'h02}, {3'd0, 8'h03, 8'h20},
        {3'd0, 8'h23, 8'h40}, {3'd0, 8'h63, 8'h00}, {3'd1, 8'h00, 8'h01},
        {3'd1, 8'h01, 8'h40}, {3'd1, 8'h41, 8'h00}, {3'd2, 8'h00, 8'h01},
        {3'd2, 8'h01, 8'h02}, {3'd3, 8'h00, 8'h04}, {3'd3, 8'h04, 8'h08},
        {3'd3, 8'h0C, 8'h00}, {3'd4, 8'h0C, 8'h80}, {3'd4, 8'h00, 8'h04},
        {3'd5, 8'h00, 8'h10}, {3'd5, 8'h10, 8'h00}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_issue(input int p, input logic [UW-1:0] uid, input string req);
        chk({31'd0, iv[p]}, 32'd1, req, $sformatf("port %0d valid", p));
        chk({24'd0, iuid[p]}, {24'd0, uid}, req, $sformatf("port %0d uid", p));
    endtask

    task automatic clear_in();
        a_v = '0; a_cls = '0; a_tag = '0; a_rdy = '0; a_uid = '0;
        w_v = '0; w_tag = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        clear_in();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; clear_in(); busy = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic put(input int l, input logic [2:0] c, input logic [UW-1:0] u,
                       input logic r0, input logic [TW-1:0] t0,
                       input logic r1, input logic [TW-1:0] t1);
        a_v[l] = 1'b1; a_cls[l] = c; a_uid[l] = u;
        a_rdy[l][0] = r0; a_tag[l][0] = t0;
        a_rdy[l][1] = r1; a_tag[l][1] = t1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        clear_in();
        busy = '0;

        // R9: reset state
        do_reset();
        #5;
        chk({24'd0, iv}, 32'd0, "R9", "issue after reset");
        chk({31'd0, a_ok}, 32'd1, "R9", "alloc_ok after reset");

        // R2/R5/R6/R8: class-to-port table
        for (int r = 0; r < 17; r++) begin
            do_reset();
            busy = VEC[r][15:8];
            put(0, VEC[r][18:16], UW'(8'h60 + r), 1'b1, '0, 1'b1, '0);
            #5;
            chk({24'd0, iv}, 32'd0, "R8", $sformatf("row %0d alloc cycle", r));
            tick();
            #5;
            chk({24'd0, iv}, {24'd0, VEC[r][7:0]}, "R2", $sformatf("row %0d issue mask", r));
            for (int p = 0; p < 8; p++)
                if (VEC[r][p]) chk({24'd0, iuid[p]}, 32'h60 + r, "R2", $sformatf("row %0d uid", r));
            tick();
            #5;
            if (VEC[r][7:0] != 8'h00)
                chk({24'd0, iv}, 32'd0, "R8", $sformatf("row %0d freed", r));
        end

        // R4/R5: four ALU µops spread in age order
        do_reset();
        busy = 8'hFF;
        put(0, 3'd0, 8'd10, 1'b1, '0, 1'b1, '0);
        put(1, 3'd0, 8'd11, 1'b1, '0, 1'b1, '0);
        tick();
        put(0, 3'd0, 8'd12, 1'b1, '0, 1'b1, '0);
        put(1, 3'd0, 8'd13, 1'b1, '0, 1'b1, '0);
        tick();
        busy = 8'h00;
        #5;
        chk({24'd0, iv}, 32'h63, "R5", "four-wide mask");
        chk_issue(0, 8'd10, "R4");
        chk_issue(1, 8'd11, "R4");
        chk_issue(5, 8'd12, "R5");
        chk_issue(6, 8'd13, "R5");
        tick();
        #5;
        chk({24'd0, iv}, 32'd0, "R3", "no reissue");

        // R4: age beats slot index
        do_reset();
        busy = 8'hFF;
        put(0, 3'd0, 8'd20, 1'b1, '0, 1'b1, '0);
        put(1, 3'd0, 8'd21, 1'b1, '0, 1'b1, '0);
        tick();
        busy = 8'hFE;
        #5 chk_issue(0, 8'd20, "R4");
        tick();
        busy = 8'hFF;
        put(0, 3'd0, 8'd22, 1'b1, '0, 1'b1, '0);
        tick();
        busy = 8'hFE;
        #5 chk_issue(0, 8'd21, "R4");
        tick();
        #5 chk_issue(0, 8'd22, "R4");
        tick();
        #5 chk({24'd0, iv}, 32'd0, "R3", "drained");

        // R5: mixed classes, port order
        do_reset();
        busy = 8'hFF;
        put(0, 3'd1, 8'd70, 1'b1, '0, 1'b1, '0);
        put(1, 3'd0, 8'd71, 1'b1, '0, 1'b1, '0);
        tick();
        busy = 8'h00;
        #5;
        chk_issue(0, 8'd70, "R5");
        chk_issue(1, 8'd71, "R5");
        do_reset();
        busy = 8'hFF;
        put(0, 3'd0, 8'd72, 1'b1, '0, 1'b1, '0);
        put(1, 3'd1, 8'd73, 1'b1, '0, 1'b1, '0);
        tick();
        busy = 8'h00;
        #5;
        chk({24'd0, iv}, 32'h41, "R5", "alu older mask");
        chk_issue(0, 8'd72, "R5");
        chk_issue(6, 8'd73, "R5");

        // R7: wakeup timing
        do_reset();
        put(0, 3'd0, 8'd30, 1'b0, 6'd5, 1'b1, '0);
        tick();
        #5 chk({24'd0, iv}, 32'd0, "R7", "waiting source");
        w_v[0] = 1'b1; w_tag[0] = 6'd5;
        #5 chk({24'd0, iv}, 32'd0, "R7", "wake cycle");
        tick();
        #5 chk_issue(0, 8'd30, "R7");
        tick();
        put(0, 3'd0, 8'd31, 1'b0, 6'd9, 1'b1, '0);
        tick();
        w_v[1] = 1'b1; w_tag[1] = 6'd8;
        tick();
        #5 chk({24'd0, iv}, 32'd0, "R7", "non-matching tag");
        w_v[1] = 1'b1; w_tag[1] = 6'd9;
        tick();
        #5 chk_issue(0, 8'd31, "R7");
        tick();
        put(0, 3'd0, 8'd32, 1'b0, 6'd12, 1'b1, '0);
        w_v[0] = 1'b1; w_tag[0] = 6'd12;
        tick();
        #5 chk_issue(0, 8'd32, "R7");
        tick();
        put(0, 3'd0, 8'd33, 1'b1, '0, 1'b0, 6'd3);
        tick();
        #5 chk({24'd0, iv}, 32'd0, "R7", "second source waiting");
        w_v[0] = 1'b1; w_tag[0] = 6'd3;
        tick();
        #5 chk_issue(0, 8'd33, "R7");

        // R1: full pool and partial refusal
        do_reset();
        busy = 8'hFF;
        put(0, 3'd0, 8'd40, 1'b1, '0, 1'b1, '0);
        put(1, 3'd0, 8'd41, 1'b1, '0, 1'b1, '0);
        #5 chk({31'd0, a_ok}, 32'd1, "R1", "fill 1");
        tick();
        put(0, 3'd0, 8'd42, 1'b1, '0, 1'b1, '0);
        put(1, 3'd0, 8'd43, 1'b1, '0, 1'b1, '0);
        #5 chk({31'd0, a_ok}, 32'd1, "R1", "fill 2");
        tick();
        put(0, 3'd0, 8'd44, 1'b1, '0, 1'b1, '0);
        put(1, 3'd0, 8'd45, 1'b1, '0, 1'b1, '0);
        #5 chk({31'd0, a_ok}, 32'd1, "R1", "fill 3");
        tick();
        put(0, 3'd0, 8'd46, 1'b1, '0, 1'b1, '0);
        #5 chk({31'd0, a_ok}, 32'd0, "R1", "full refuse");
        tick();
        busy = 8'hFE;
        #5 chk_issue(0, 8'd40, "R1");
        tick();
        busy = 8'hFF;
        put(0, 3'd0, 8'd47, 1'b1, '0, 1'b1, '0);
        put(1, 3'd0, 8'd48, 1'b1, '0, 1'b1, '0);
        #5 chk({31'd0, a_ok}, 32'd0, "R1", "two into one refused");
        tick();
        put(0, 3'd0, 8'd49, 1'b1, '0, 1'b1, '0);
        #5 chk({31'd0, a_ok}, 32'd1, "R1", "one into one accepted");
        tick();
        busy = 8'hFE;
        foreach (VEC[k]) begin
            if (k < 6) begin
                #5 chk_issue(0, (k == 5) ? 8'd49 : UW'(41 + k), "R1");
                tick();
            end
        end
        #5 chk({24'd0, iv}, 32'd0, "R1", "refused never issued");

        // R6: stalled store-data port keeps its µop
        do_reset();
        busy = 8'h10;
        put(0, 3'd5, 8'd50, 1'b1, '0, 1'b1, '0);
        tick();
        #5 chk({24'd0, iv}, 32'd0, "R6", "stall 1");
        tick();
        #5 chk({24'd0, iv}, 32'd0, "R6", "stall 2");
        busy = 8'h00;
        #5 chk_issue(4, 8'd50, "R6");
        tick();
        #5 chk({24'd0, iv}, 32'd0, "R6", "after release");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule